// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words of 18 bits enter on the write clock and leave on the read clock. The storage depth is two to the power of a parameter, so simulation can use a small buffer while a product build uses thousands of words. A timing-mode input is sampled only while master reset is held. It selects one of two read behaviours. In standard mode a word is moved to the output register only when the reader asks for it. In fall-through mode the oldest word is placed on the output as soon as it arrives.

The two level outputs change meaning with the mode. In standard mode they are a full flag and an empty flag. In fall-through mode they report space available and a valid word on the output. Three more outputs report the fill level: a half-full indication, an almost-full indication and an almost-empty indication. The almost-full and almost-empty thresholds come from an external offset block as plain input vectors.

Master reset clears the FIFO and latches the mode. Partial reset clears the FIFO and keeps the mode. Retransmit rewinds only the read side, so that stored data can be read again from the first storage location.

Top module: `dcf_fifo`

## Requirements
- R1: While `mrst` is held, both pointers and `rd_data` are cleared and the mode is latched from `mode_sel` (0 = standard, 1 = fall-through). After release, with `full_ofs`=3 and `empty_ofs`=4, a standard-mode FIFO shows `rd_data`=0, `wr_flag`=0, `rd_flag`=1, `hf_n`=1, `paf_n`=1 and `pae_n`=0.
- R2: In standard mode, `rd_en` sampled high on a read-clock edge while words are stored loads the oldest word into `rd_data` at that edge. Words leave in the order they were written.
- R3: `wr_flag` is 1 exactly when the memory holds 2^AW words in standard mode. In fall-through mode it is inverted, so 1 means space is available.
- R4: In standard mode `rd_flag` is 1 when no word is stored. In fall-through mode `rd_flag` is 1 while `rd_data` holds a valid, unread word.
- R5: A write while the memory is full is dropped. A read request while nothing is readable leaves `rd_data` unchanged.
- R6: In fall-through mode the oldest word appears on `rd_data` without a read request. A read-clock edge with `rd_en` high and `rd_flag` 1 consumes it and presents the next word at the same edge, if one is stored.
- R7: `paf_n` is 0 exactly when the write-side word count exceeds 2^AW − `full_ofs`.
- R8: `pae_n` is 0 exactly when the read-side word count is below `empty_ofs`. In fall-through mode the read-side count includes the word held on `rd_data`.
- R9: `hf_n` is 0 exactly when the write-side word count exceeds 2^(AW−1).
- R10: `prst` clears both pointers and `rd_data`. It keeps the latched mode whatever `mode_sel` is.
- R11: `rt` sampled on a read-clock edge returns the read pointer to location 0, so stored words are read again from the first. The write pointer is unchanged, and the next write lands after the last word written.
- R12: On the read-clock cycle after `rt`, `rd_flag` is forced to show nothing readable: 1 in standard mode, 0 in fall-through mode.
- R13: Each pointer crosses into the other clock domain as a Gray code. Apart from resets and retransmit, the code changes in at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high, held for several cycles of both clocks |
| prst | input | 1 | Partial reset, synchronous, active high, held for several cycles of both clocks |
| mode_sel | input | 1 | Timing mode sampled during master reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request, write clock domain |
| wr_data | input | 18 | Word to store |
| full_ofs | input | AW+1 | Almost-full offset |
| rd_en | input | 1 | Read request, read clock domain |
| rt | input | 1 | Retransmit request, read clock domain |
| empty_ofs | input | AW+1 | Almost-empty offset |
| rd_data | output | 18 | Output register |
| wr_flag | output | 1 | Full (standard) or space available (fall-through) |
| rd_flag | output | 1 | Empty (standard) or output valid (fall-through) |
| hf_n | output | 1 | Low when more than half full |
| paf_n | output | 1 | Low when almost full |
| pae_n | output | 1 | Low when almost empty |

## Verification
The bench fills a 16-word configuration one word at a time and then drains it one word at a time. At every level it checks the full, half, almost-full and almost-empty thresholds against arithmetic, so each off-by-one in a comparison shows up at a distinct fill level. A write into a full buffer and a read from an empty one tell dropped requests apart from wrap-around corruption. Retransmit runs in both modes, with a write after the rewind, which separates a read-only rewind from one that also moves the write pointer. A partial reset with `mode_sel` driven to the opposite value, followed by fall-through fills up to the full memory plus the output word, shows whether the mode was kept and whether the output word is counted.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        TM_STD  = 1'b0,
        TM_FWFT = 1'b1
    } tmode_e;

    typedef struct packed {
        logic lvl;
        logic hf_n;
        logic paf_n;
    } wflags_t;

    typedef struct packed {
        logic lvl;
        logic pae_n;
    } rflags_t;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage;

    always_ff @(posedge clk) begin
        if (clr) begin
            stage <= '0;
            q     <= '0;
        end else begin
            stage <= d;
            q     <= stage;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [AW:0]   full_ofs,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW:0]   wptr,
    output tmode_e        mode,
    output wflags_t       flags
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [AW:0] rbin;
    logic [AW:0] cnt;
    logic [AW:0] wnext;
    logic        full;

    // Gray to binary: each bit is the parity of itself and all bits above.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin[i] = ^(rgray_s >> i);
        end
    end

    assign cnt   = wptr - rbin;
    assign full  = (cnt == PW'(DEPTH));
    assign we    = wr_en && !full;
    assign wnext = wptr + PW'(1);
    assign waddr = wptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode <= tmode_e'(mode_sel);
        end
        if (mrst || prst) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (we) begin
            wptr  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    always_comb begin
        flags.lvl   = (mode == TM_STD) ? full : !full;
        flags.hf_n  = !(cnt > PW'(DEPTH / 2));
        flags.paf_n = !(({1'b0, cnt} + {1'b0, full_ofs}) > (PW + 1)'(DEPTH));
    end
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside
    import dcf_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          mode_sel,
    input  logic          rd_en,
    input  logic          rt,
    input  logic [AW:0]   empty_ofs,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [AW:0]   rptr,
    output tmode_e        mode,
    output logic [DW-1:0] rd_data,
    output rflags_t       flags
);
    localparam int PW = AW + 1;

    logic [AW:0] wbin;
    logic [AW:0] mcnt;
    logic [AW:0] rnext;
    logic [AW+1:0] rcnt;
    logic        mem_empty;
    logic        oval;
    logic        rt_hold;
    logic        pop_std;
    logic        take;
    logic        load;
    logic        adv;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin[i] = ^(wgray_s >> i);
        end
    end

    assign mcnt      = wbin - rptr;
    assign mem_empty = (mcnt == '0);
    assign rnext     = rptr + PW'(1);
    assign raddr     = rptr[AW-1:0];

    assign pop_std = rd_en && !mem_empty && !rt_hold;
    assign take    = oval && rd_en;
    assign load    = !mem_empty && !rt_hold && (!oval || take);
    assign adv     = (mode == TM_STD) ? pop_std : load;

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode <= tmode_e'(mode_sel);
        end
        if (mrst || prst) begin
            rptr    <= '0;
            rgray   <= '0;
            rd_data <= '0;
            oval    <= 1'b0;
            rt_hold <= 1'b0;
        end else if (rt) begin
            rptr    <= '0;
            rgray   <= '0;
            oval    <= 1'b0;
            rt_hold <= 1'b1;
        end else begin
            rt_hold <= 1'b0;
            if (adv) begin
                rptr    <= rnext;
                rgray   <= rnext ^ (rnext >> 1);
                rd_data <= mem_q;
            end
            if (mode == TM_FWFT) begin
                if (load) begin
                    oval <= 1'b1;
                end else if (take) begin
                    oval <= 1'b0;
                end
            end
        end
    end

    assign rcnt = {1'b0, mcnt} + (PW + 1)'(oval && (mode == TM_FWFT));

    always_comb begin
        flags.lvl   = (mode == TM_STD) ? (mem_empty || rt_hold) : oval;
        flags.pae_n = !(rcnt < {1'b0, empty_ofs});
    end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   full_ofs,
    input  logic          rd_en,
    input  logic          rt,
    input  logic [AW:0]   empty_ofs,
    output logic [DW-1:0] rd_data,
    output logic          wr_flag,
    output logic          rd_flag,
    output logic          hf_n,
    output logic          paf_n,
    output logic          pae_n
);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_q;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [PW-1:0] wptr, rptr;
    tmode_e        wmode, rmode;
    wflags_t       wfl;
    rflags_t       rfl;
    logic          rst_any;

    assign rst_any = mrst || prst;

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .clr(rst_any), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .clr(rst_any), .d(rgray), .q(rgray_s)
    );

    dcf_wside #(.AW(AW)) u_ws (
        .clk(wr_clk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
        .wr_en(wr_en), .full_ofs(full_ofs), .rgray_s(rgray_s),
        .we(we), .waddr(waddr), .wgray(wgray), .wptr(wptr),
        .mode(wmode), .flags(wfl)
    );

    dcf_rside #(.DW(DW), .AW(AW)) u_rs (
        .clk(rd_clk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
        .rd_en(rd_en), .rt(rt), .empty_ofs(empty_ofs), .wgray_s(wgray_s),
        .mem_q(mem_q), .raddr(raddr), .rgray(rgray), .rptr(rptr),
        .mode(rmode), .rd_data(rd_data), .flags(rfl)
    );

    assign wr_flag = wfl.lvl;
    assign hf_n    = wfl.hf_n;
    assign paf_n   = wfl.paf_n;
    assign rd_flag = rfl.lvl;
    assign pae_n   = rfl.pae_n;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk
    import dcf_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst,
    input logic          prst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rt,
    input logic          wr_flag,
    input logic          rd_flag,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   wptr,
    input logic [AW:0]   rptr,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray,
    input logic [AW:0]   rgray_s,
    input tmode_e        wmode,
    input tmode_e        rmode
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [AW:0] rbin_w;
    logic [AW:0] wcnt;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin_w[i] = ^(rgray_s >> i);
        end
    end
    assign wcnt = wptr - rbin_w;

    a_r5_no_write_when_full: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        (wmode == TM_STD && wr_flag && wr_en) |=> $stable(wptr));

    a_r3_count_bound: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        wcnt <= PW'(DEPTH));

    a_r5_no_read_when_empty: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (rmode == TM_STD && rd_flag && rd_en) |=> $stable(rd_data));

    a_r6_output_held: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (rmode == TM_FWFT && rd_flag && !rd_en && !rt) |=> ($stable(rd_data) && rd_flag));

    a_r11_rewind: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        rt |=> (rptr == '0));

    a_r10_wmode_kept: assert property (@(posedge wr_clk) disable iff (mrst)
        !mrst |=> $stable(wmode));

    a_r10_rmode_kept: assert property (@(posedge rd_clk) disable iff (mrst)
        !mrst |=> $stable(rmode));

    a_r13_wgray_onebit: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        !$past(mrst || prst) |-> ($countones(wgray ^ $past(wgray)) <= 1));

    a_r13_rgray_onebit: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (!$past(mrst || prst) && !$past(rt)) |-> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
    .wr_en(wr_en), .rd_en(rd_en), .rt(rt), .wr_flag(wr_flag),
    .rd_flag(rd_flag), .rd_data(rd_data), .wptr(wptr), .rptr(rptr),
    .wgray(wgray), .rgray(rgray), .rgray_s(rgray_s),
    .wmode(wmode), .rmode(rmode)
);

// File: tb/tb_dcf_fifo.sv
`timescale 1ns/1ps
module tb_dcf_fifo;
    localparam int DW    = 18;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int FOFS  = 3;
    localparam int EOFS  = 4;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mrst = 1'b1;
    logic          prst = 1'b0;
    logic          mode_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW:0]   full_ofs = (AW + 1)'(FOFS);
    logic          rd_en = 1'b0;
    logic          rt = 1'b0;
    logic [AW:0]   empty_ofs = (AW + 1)'(EOFS);
    logic [DW-1:0] rd_data;
    logic          wr_flag, rd_flag, hf_n, paf_n, pae_n;

    int checks = 0;
    int errors = 0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    dcf_fifo #(.DW(DW), .AW(AW)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
        .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data),
        .full_ofs(full_ofs), .rd_en(rd_en), .rt(rt), .empty_ofs(empty_ofs),
        .rd_data(rd_data), .wr_flag(wr_flag), .rd_flag(rd_flag),
        .hf_n(hf_n), .paf_n(paf_n), .pae_n(pae_n)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 1237 + 341);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge rd_clk);
    endtask

    task automatic do_reset(input bit master, input logic msel);
        @(negedge wr_clk);
        mode_sel = msel;
        if (master) mrst = 1'b1; else prst = 1'b1;
        repeat (3) @(negedge wr_clk);
        repeat (3) @(negedge rd_clk);
        mrst = 1'b0;
        prst = 1'b0;
        @(negedge rd_clk);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pull();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_rt();
        @(negedge rd_clk);
        rt = 1'b1;
        @(negedge rd_clk);
        rt = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state, standard mode
        do_reset(1'b1, 1'b0);
        settle();
        chk("R1 rd_data", 32'(rd_data), 0);
        chk("R1 wr_flag", 32'(wr_flag), 0);
        chk("R1 rd_flag", 32'(rd_flag), 1);
        chk("R1 hf_n", 32'(hf_n), 1);
        chk("R1 paf_n", 32'(paf_n), 1);
        chk("R1 pae_n", 32'(pae_n), 0);

        // Fill sweep: R3 R4 R7 R8 R9
        for (int k = 1; k <= DEPTH; k++) begin
            push(pat(k - 1));
            settle();
            chk("R3 full", 32'(wr_flag), 32'(k == DEPTH));
            chk("R9 half", 32'(hf_n), 32'(!(k > DEPTH / 2)));
            chk("R7 almost full", 32'(paf_n), 32'(!(k > DEPTH - FOFS)));
            chk("R4 not empty", 32'(rd_flag), 0);
            chk("R8 almost empty", 32'(pae_n), 32'(!(k < EOFS)));
        end

        // R5 write into full memory is dropped
        push(pat(99));
        settle();
        chk("R5 still full", 32'(wr_flag), 1);

        // Drain sweep: R2 order, levels going down
        for (int j = 0; j < DEPTH; j++) begin
            pull();
            chk("R2 data", 32'(rd_data), 32'(pat(j)));
            settle();
            chk("R8 almost empty down", 32'(pae_n), 32'(!((DEPTH - 1 - j) < EOFS)));
            chk("R9 half down", 32'(hf_n), 32'(!((DEPTH - 1 - j) > DEPTH / 2)));
            chk("R4 empty", 32'(rd_flag), 32'((DEPTH - 1 - j) == 0));
            chk("R3 not full", 32'(wr_flag), 0);
        end

        // R5 read from empty leaves output
        pull();
        chk("R5 empty read data", 32'(rd_data), 32'(pat(DEPTH - 1)));
        chk("R5 empty read flag", 32'(rd_flag), 1);

        // R11 R12 retransmit, standard mode
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) push(pat(20 + i));
        settle();
        pull();
        chk("R2 first", 32'(rd_data), 32'(pat(20)));
        pull();
        chk("R2 second", 32'(rd_data), 32'(pat(21)));
        pulse_rt();
        chk("R12 std empty pulse", 32'(rd_flag), 1);
        @(negedge rd_clk);
        chk("R12 std pulse ends", 32'(rd_flag), 0);
        for (int i = 0; i < 5; i++) begin
            pull();
            chk("R11 reread", 32'(rd_data), 32'(pat(20 + i)));
        end
        push(pat(30));
        settle();
        pull();
        chk("R11 write pointer kept", 32'(rd_data), 32'(pat(30)));

        // R6 fall-through mode
        do_reset(1'b1, 1'b1);
        settle();
        chk("R3 fwft space", 32'(wr_flag), 1);
        chk("R4 fwft no word", 32'(rd_flag), 0);
        chk("R1 fwft data", 32'(rd_data), 0);
        for (int i = 0; i < 3; i++) push(pat(40 + i));
        settle();
        chk("R6 falls through", 32'(rd_data), 32'(pat(40)));
        chk("R4 fwft valid", 32'(rd_flag), 1);
        chk("R8 fwft count", 32'(pae_n), 0);
        pull();
        chk("R6 next word", 32'(rd_data), 32'(pat(41)));
        pull();
        chk("R6 third word", 32'(rd_data), 32'(pat(42)));
        pull();
        chk("R4 fwft drained", 32'(rd_flag), 0);
        chk("R6 data held", 32'(rd_data), 32'(pat(42)));
        pull();
        chk("R5 fwft empty read", 32'(rd_data), 32'(pat(42)));

        // R12 R11 retransmit, fall-through
        pulse_rt();
        chk("R12 fwft ready drop", 32'(rd_flag), 0);
        settle();
        chk("R11 fwft reread flag", 32'(rd_flag), 1);
        chk("R11 fwft reread", 32'(rd_data), 32'(pat(40)));

        // R10 partial reset keeps fall-through mode
        do_reset(1'b0, 1'b0);
        chk("R10 data cleared", 32'(rd_data), 0);
        chk("R10 no word", 32'(rd_flag), 0);
        chk("R10 mode kept", 32'(wr_flag), 1);
        push(pat(50));
        settle();
        chk("R10 falls through", 32'(rd_flag), 1);
        chk("R10 word", 32'(rd_data), 32'(pat(50)));

        // R3 R7 R8 R9 fall-through full: memory plus output word
        @(negedge wr_clk);
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1'b1;
            wr_data = pat(60 + i);
            @(negedge wr_clk);
        end
        wr_en = 1'b0;
        settle();
        chk("R3 fwft no space", 32'(wr_flag), 0);
        chk("R7 fwft almost full", 32'(paf_n), 0);
        chk("R9 fwft half", 32'(hf_n), 0);
        chk("R8 fwft counts output", 32'(pae_n), 1);
        pull();
        chk("R6 after full", 32'(rd_data), 32'(pat(60)));
        settle();
        chk("R3 fwft space back", 32'(wr_flag), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule